// File: doc/BRIEF.md
# Edge-Kicked Activity Watchdog

This block watches a single activity line driven by a processor. Software toggles the line as it runs. Every transition on the line, in either direction, restarts a long idle count. If the line stays still for the whole timeout, the block raises a request for one clock cycle. The system's reset generator takes that request and stretches it into a reset pulse.

The reset generator feeds its active-high reset status back into the block. While that status is high, the idle count is forced to zero and stays there. When the activity line is left static, the block therefore fires again and again. Each new timeout starts only once the previous reset pulse has ended.

The activity line is asynchronous to the block's clock. It passes through a synchronizer before edges are detected. An enable input turns the whole function off, which stands in for leaving the activity line unconnected. All durations are parameters counted in clock cycles.

Top module: `activity_watchdog`

## Requirements
- R1: After the last clock edge at which the count was cleared, `expire_o` is high in exactly the cycle after the TIMEOUT_CYCLES-th following rising clock edge, provided nothing clears the count in between.
- R2: With SYNC_STAGES = 2, a change of `wdi_i` first sampled on clock edge a clears the count at edge a+2. The next request therefore appears after edge a+2+TIMEOUT_CYCLES.
- R3: Rising and falling transitions of `wdi_i` both restart the count. Toggling `wdi_i` at intervals shorter than the timeout produces no request.
- R4: `expire_o` is never high for two consecutive cycles.
- R5: While `wdi_i` is static, `enable_i` is high and `rst_active_i` stays low, requests repeat exactly every TIMEOUT_CYCLES cycles.
- R6: If `rst_active_i` is held high for P cycles starting in the cycle after each request, successive requests are spaced exactly TIMEOUT_CYCLES + P cycles apart.
- R7: While `enable_i` is low, the count is held at zero and no request is issued. A request after re-enabling needs a full TIMEOUT_CYCLES.
- R8: A `wdi_i` pulse lasting one clock period is recognised as activity on both of its edges.
- R9: While `rst_active_i` is high, the count is held at zero and `expire_o` is low in the following cycle. A request after release needs a full TIMEOUT_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| wdi_i | input | 1 | Asynchronous activity line toggled by software |
| enable_i | input | 1 | High to run the watchdog; low holds it idle |
| rst_active_i | input | 1 | Active-high reset status from the reset generator |
| expire_o | output | 1 | One-cycle timeout request to the reset generator |

## Verification
On every cycle, the assertions check four things:
- the request is a single cycle wide;
- requests never come closer together than the timeout;
- the count stays below its terminal value;
- both reset status and a low enable suppress the request and hold the count at zero.

Some behaviours involve exact timing, and only the bench scenarios can show them. These are:
- the exact cycle of the first request after release;
- the two-edge synchronizer latency from a transition to the restart;
- recognition of one-cycle pulses;
- a request spacing that stretches with the reset pulse length.

A behavioural model in the bench predicts `expire_o` on every cycle through all of these scenarios.

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
  parameter int TIMEOUT_CYCLES = 40,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic wdi_i,
  input  logic enable_i,
  input  logic rst_active_i,
  output logic expire_o
);
  localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          cnt_q;

  wire toggled = sync_q[SYNC_STAGES-1] ^ prev_q;
  wire clear   = rst_active_i | ~enable_i | toggled;
  wire at_end  = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], wdi_i};
    prev_q <= sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (clear || at_end) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
    expire_o <= ~clear & at_end;
  end
endmodule

// File: rtl/activity_watchdog_chk.sv
module activity_watchdog_chk #(
  parameter int TIMEOUT_CYCLES = 40,
  localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1
) (
  input logic          clk,
  input logic          enable_i,
  input logic          rst_active_i,
  input logic          expire_o,
  input logic [CW-1:0] cnt_q
);
  logic   armed = 1'b0;
  logic   seen  = 1'b0;
  integer gap   = 0;

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    if (expire_o) begin
      seen <= 1'b1;
      gap  <= 1;
    end else if (gap < TIMEOUT_CYCLES) begin
      gap <= gap + 1;
    end
  end

  assert_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (!armed)
    rst_active_i |=> !expire_o);
  assert_clear_in_reset_R9: assert property (@(posedge clk) disable iff (!armed)
    rst_active_i |=> cnt_q == '0);
  assert_disabled_R7: assert property (@(posedge clk) disable iff (!armed)
    !enable_i |=> (!expire_o && cnt_q == '0));
  assert_single_cycle_R4: assert property (@(posedge clk) disable iff (rst_active_i)
    expire_o |=> !expire_o);
  assert_min_spacing_R5: assert property (@(posedge clk) disable iff (rst_active_i)
    (expire_o && seen) |-> gap >= TIMEOUT_CYCLES);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!armed)
    int'(cnt_q) < TIMEOUT_CYCLES);
endmodule

bind activity_watchdog activity_watchdog_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .enable_i(enable_i), .rst_active_i(rst_active_i),
  .expire_o(expire_o), .cnt_q(cnt_q)
);

// File: tb/tb_activity_watchdog.sv
module tb_activity_watchdog;
  localparam int T = 40;
  localparam int P = 12;

  logic clk = 0, wdi = 0, en = 0, force_rst = 1, stretch_on = 0;
  int   stretch = 0;
  logic rst_act;
  logic expire;
  assign rst_act = force_rst | (stretch != 0);

  activity_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) dut (
    .clk(clk), .wdi_i(wdi), .enable_i(en), .rst_active_i(rst_act), .expire_o(expire));

  always #5 clk = ~clk;

  int    checks = 0, fails = 0, cyc = 0, n_exp = 0, last_exp = -1, prev_gap = -1;
  string req = "R9";
  logic  hist[$] = '{1'b0, 1'b0, 1'b0};
  int    idle = 0;
  logic  exp_m = 0;

  function automatic void check(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endfunction

  // reference model: a change seen two samples back restarts the idle count
  always @(posedge clk) begin
    bit chg, clr;
    hist.push_back(wdi);
    if (hist.size() > 8) void'(hist.pop_front());
    chg   = hist[hist.size()-3] != hist[hist.size()-4];
    clr   = rst_act || !en || chg;
    exp_m = !clr && (idle == T - 1);
    idle  = (clr || idle == T - 1) ? 0 : idle + 1;
  end

  always @(negedge clk) begin
    cyc++;
    check(expire === exp_m, req, int'(expire), int'(exp_m));
    if (expire) begin
      if (last_exp >= 0) prev_gap = cyc - last_exp;
      last_exp = cyc;
      n_exp++;
    end
    if (stretch != 0) stretch--;
    if (expire && stretch_on) stretch = P;
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, base;
    step(3);
    en = 1;
    step(4);
    check(expire == 0, "R9", int'(expire), 0);

    req = "R1";
    force_rst = 0; t0 = cyc;
    while (n_exp == 0) step(1);
    check(last_exp - t0 == T, "R1", last_exp - t0, T);

    req = "R5";
    while (n_exp < 2) step(1);
    check(prev_gap == T, "R5", prev_gap, T);
    step(1);
    check(expire == 0, "R4", int'(expire), 0);

    req = "R3"; base = n_exp;
    repeat (8) begin step(T/2); wdi = ~wdi; end
    check(n_exp == base, "R3", n_exp - base, 0);
    req = "R2"; t0 = cyc;
    while (n_exp == base) step(1);
    check(last_exp - t0 == T + 3, "R2", last_exp - t0, T + 3);

    req = "R8"; step(2); base = n_exp;
    repeat (6) begin step(T/2); wdi = 1; step(1); wdi = 0; end
    check(n_exp == base, "R8", n_exp - base, 0);

    req = "R7"; en = 0; base = n_exp;
    step(3*T);
    check(n_exp == base, "R7", n_exp - base, 0);
    en = 1; t0 = cyc;
    while (n_exp == base) step(1);
    check(last_exp - t0 == T, "R7", last_exp - t0, T);

    req = "R9"; step(T/2); base = n_exp;
    force_rst = 1; step(5);
    check(n_exp == base && expire == 0, "R9", n_exp - base, 0);
    force_rst = 0; t0 = cyc;
    while (n_exp == base) step(1);
    check(last_exp - t0 == T, "R9", last_exp - t0, T);

    req = "R6"; stretch_on = 1; base = n_exp;
    while (n_exp < base + 2) step(1);
    check(prev_gap == T + P, "R6", prev_gap, T + P);
    stretch_on = 0;
    step(P + 2);
    finish_run();
  end
endmodule